// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, day of month, weekday, month (with a century flag) and a two-digit year. A one-cycle enable marks each elapsed second. Every second the core advances the seconds field, and carries ripple through the longer units. Month lengths and leap years are handled in hardware.

All state is visible through a small byte-addressed register file, in the layout that a serial register bridge placed in front of it expects. A control byte holds a freeze bit, which software sets while it rewrites the time and clears afterwards. The seconds byte has a sticky integrity flag in its top bit. Power-on sets this flag, and it stays set until software writes a trusted time. Other blocks can use a one-cycle pulse that marks each minute boundary.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: 0x00 = 0x00, 0x02 = 0x80 (integrity flag set, seconds 00), 0x03 = 0x00, 0x04 = 0x00, 0x05 = 0x01, 0x06 = 0x00, 0x07 = 0x01, 0x08 = 0x00.
- R2: Register map: 0x00 control, 0x02 seconds, 0x03 minutes, 0x04 hours, 0x05 day, 0x06 weekday, 0x07 month, 0x08 year. A write keeps only the field bits: 0x7F for seconds and minutes, 0x3F for hours and day, 0x07 for weekday, 0x9F for month, 0xFF for year and 0xA8 for control. Any other address reads 0x00 and ignores writes.
- R3: When a tick arrives and the freeze bit is clear, seconds advance by one. A seconds value at or above 59 wraps to 00 and advances minutes. A minutes value at or above 59 wraps to 00 and advances hours. An hours value at or above 23 wraps to 00 and advances the day.
- R4: The weekday advances on every day advance and wraps from 6 to 0.
- R5: A day value at or above the month's last day wraps to 01 and advances the month. April, June, September and November have 30 days, February has 28 days, and the other months have 31.
- R6: February has 29 days when the binary value of the BCD year is divisible by 4 (year 00 included).
- R7: A month value at or above 12 wraps to 01 and advances the year. A year value at or above 99 wraps to 00 and toggles the century flag (bit 7 of the month byte).
- R8: While bit 5 of the control byte is 1, no time field changes on a tick, and ticks received during that time are lost.
- R9: Control bits 7 and 3 are stored and read back, and they have no effect on counting.
- R10: The integrity flag (bit 7 of the seconds byte) is set by reset and takes bit 7 of every write to the seconds byte. Counting never changes it.
- R11: `sec_rollover` goes high for exactly one cycle, in the cycle after the clock edge that wraps seconds to 00.
- R12: A tick that arrives in the same cycle as any register write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_1hz | input | 1 | One-cycle enable per elapsed second |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | ADDR_W | Register read address |
| reg_rd_data | output | 8 | Combinational read data |
| sec_rollover | output | 1 | One-cycle pulse after seconds wrap to 00 |

## Verification
The embedded properties assume the following about the inputs: `tick_1hz` is a single-cycle enable, writes last one cycle, and a field whose value lies beyond its range wraps on its next carry and never holds there. The stimulus writes only legal BCD values for each field. It is allowed to place a day beyond the current month's last day, because the wrap rule defines what happens next. The stimulus issues ticks back to back, which is far faster than one per second, so that carries from seconds through to the century occur within the run. Writes and ticks are driven on the falling edge, so each one is seen exactly once.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_TIME = 7;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_SEC  = 2;
  localparam int unsigned A_MIN  = 3;
  localparam int unsigned A_HOUR = 4;
  localparam int unsigned A_DAY  = 5;
  localparam int unsigned A_WDAY = 6;
  localparam int unsigned A_MON  = 7;
  localparam int unsigned A_YEAR = 8;

  localparam int unsigned STOP_BIT = 5;
  localparam logic [7:0] CTRL_KEEP = 8'hA8;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_t;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bin);
    return (year_bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon_bin,
                                           input logic [7:0] year_bin);
    case (mon_bin)
      8'd2:                      return is_leap(year_bin) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter int unsigned W     = 7,
  parameter logic [7:0]  FIRST = 8'h00,
  parameter logic [7:0]  RST   = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic [7:0]   last_bin,
  output logic [W-1:0] val,
  output logic         carry
);

  logic [7:0] cur_bin;
  logic [7:0] nxt_code;
  logic       at_last;

  generate
    if (W <= 3) begin : g_binary
      assign cur_bin  = 8'(val);
      assign nxt_code = cur_bin + 8'd1;
    end else begin : g_bcd
      assign cur_bin  = bcd_to_bin(8'(val));
      assign nxt_code = bin_to_bcd(cur_bin + 8'd1);
    end
  endgenerate

  assign at_last = (cur_bin >= last_bin);
  assign carry   = step & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val <= RST[W-1:0];
    else if (ld)      val <= ld_val;
    else if (step)    val <= at_last ? FIRST[W-1:0] : nxt_code[W-1:0];
  end

  // R3: a carry out leaves the field at its first value
  p_field_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !ld) |=> (val == FIRST[W-1:0]));

  // R8: without step or load the field holds
  p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld) |=> $stable(val));

endmodule

// File: rtl/rtc_cal_chain.sv
`timescale 1ns/1ps
module rtc_cal_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [N_TIME-1:0] ld,
  input  logic [7:0]        ld_byte,
  output cal_t              now,
  output logic              century,
  output logic              sec_carry
);

  logic [6:0] sec_v, min_v;
  logic [5:0] hour_v, day_v;
  logic [2:0] wday_v;
  logic [4:0] mon_v;
  logic [7:0] year_v;
  logic       min_c, hour_c, day_c, wday_c, mon_c, year_c;
  logic [7:0] day_limit;

  assign day_limit = last_day(bcd_to_bin(8'(mon_v)), bcd_to_bin(year_v));

  rtc_bcd_field #(.W(7), .FIRST(8'h00), .RST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .ld(ld[0]), .ld_val(ld_byte[6:0]),
    .step(adv), .last_bin(8'd59), .val(sec_v), .carry(sec_carry));

  rtc_bcd_field #(.W(7), .FIRST(8'h00), .RST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .ld(ld[1]), .ld_val(ld_byte[6:0]),
    .step(sec_carry), .last_bin(8'd59), .val(min_v), .carry(min_c));

  rtc_bcd_field #(.W(6), .FIRST(8'h00), .RST(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .ld(ld[2]), .ld_val(ld_byte[5:0]),
    .step(min_c), .last_bin(8'd23), .val(hour_v), .carry(hour_c));

  rtc_bcd_field #(.W(6), .FIRST(8'h01), .RST(8'h01)) u_day (
    .clk(clk), .rst_n(rst_n), .ld(ld[3]), .ld_val(ld_byte[5:0]),
    .step(hour_c), .last_bin(day_limit), .val(day_v), .carry(day_c));

  rtc_bcd_field #(.W(3), .FIRST(8'h00), .RST(8'h00)) u_wday (
    .clk(clk), .rst_n(rst_n), .ld(ld[4]), .ld_val(ld_byte[2:0]),
    .step(hour_c), .last_bin(8'd6), .val(wday_v), .carry(wday_c));

  rtc_bcd_field #(.W(5), .FIRST(8'h01), .RST(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .ld(ld[5]), .ld_val(ld_byte[4:0]),
    .step(day_c), .last_bin(8'd12), .val(mon_v), .carry(mon_c));

  rtc_bcd_field #(.W(8), .FIRST(8'h00), .RST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .ld(ld[6]), .ld_val(ld_byte),
    .step(mon_c), .last_bin(8'd99), .val(year_v), .carry(year_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       century <= 1'b0;
    else if (ld[5])   century <= ld_byte[7];
    else if (year_c)  century <= ~century;
  end

  always_comb begin
    now.sec  = 8'(sec_v);
    now.min  = 8'(min_v);
    now.hour = 8'(hour_v);
    now.day  = 8'(day_v);
    now.wday = 8'(wday_v);
    now.mon  = 8'(mon_v);
    now.year = year_v;
  end

  // R7: a year wrap flips the century flag
  p_century_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_c && !ld[5]) |=> (century != $past(century)));

  // R5: after a day carry the day reads 01
  p_day_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_c && !ld[3]) |=> (now.day == 8'h01));

  // R4: weekday and day advance together
  p_wday_with_day_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_c && !ld[4]) |=> (now.wday != $past(now.wday)));

endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [7:0]        reg_rd_data,
  output logic              sec_rollover
);

  logic [7:0]        ctrl_q;
  logic              lost_q;
  logic              frozen;
  logic              adv;
  logic              sec_carry;
  logic              century;
  logic [N_TIME-1:0] ld;
  cal_t              now;

  generate
    for (genvar i = 0; i < N_TIME; i++) begin : g_ld
      assign ld[i] = reg_wr_en && (reg_wr_addr == ADDR_W'(A_SEC + i));
    end
  endgenerate

  assign frozen = ctrl_q[STOP_BIT];
  assign adv    = tick_1hz && !frozen && !reg_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= 8'h00;
      lost_q       <= 1'b1;
      sec_rollover <= 1'b0;
    end else begin
      if (reg_wr_en && reg_wr_addr == ADDR_W'(A_CTRL))
        ctrl_q <= reg_wr_data & CTRL_KEEP;
      if (ld[0])
        lost_q <= reg_wr_data[7];
      sec_rollover <= sec_carry;
    end
  end

  rtc_cal_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ld(ld), .ld_byte(reg_wr_data),
    .now(now), .century(century), .sec_carry(sec_carry));

  always_comb begin
    reg_rd_data = 8'h00;
    case (reg_rd_addr)
      ADDR_W'(A_CTRL): reg_rd_data = ctrl_q;
      ADDR_W'(A_SEC):  reg_rd_data = {lost_q, now.sec[6:0]};
      ADDR_W'(A_MIN):  reg_rd_data = {1'b0, now.min[6:0]};
      ADDR_W'(A_HOUR): reg_rd_data = {2'b00, now.hour[5:0]};
      ADDR_W'(A_DAY):  reg_rd_data = {2'b00, now.day[5:0]};
      ADDR_W'(A_WDAY): reg_rd_data = {5'b00000, now.wday[2:0]};
      ADDR_W'(A_MON):  reg_rd_data = {century, 2'b00, now.mon[4:0]};
      ADDR_W'(A_YEAR): reg_rd_data = now.year;
      default:         reg_rd_data = 8'h00;
    endcase
  end

  // R11: the pulse never lasts two cycles
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rollover |=> !sec_rollover);

  // R11: the pulse coincides with seconds at 00 unless a write intervened
  p_pulse_sec_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rollover |-> (now.sec == 8'h00));

  // R8: a frozen calendar keeps every field
  p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !reg_wr_en) |=> $stable(now) && $stable(century));

  // R10: a seconds write with bit 7 low clears the flag
  p_lost_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld[0] && !reg_wr_data[7]) |=> !lost_q);

  // R10: counting leaves the flag alone
  p_lost_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld[0] |=> $stable(lost_q));

  // R12: a tick alongside a write to another register is dropped
  p_tick_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && reg_wr_en && !ld[0]) |=> $stable(now.sec));

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [3:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [3:0] reg_rd_addr = '0;
  logic [7:0] reg_rd_data;
  logic       sec_rollover;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state, plain binary
  int m_s, m_m, m_h, m_d, m_w, m_mo, m_y;
  bit m_cent, m_lost;
  logic [7:0] m_ctrl;

  always #10 clk = ~clk;

  rtc_calendar_core #(.ADDR_W(4)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .sec_rollover(sec_rollover));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_days(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] model_read(input int a);
    case (a)
      0: return m_ctrl;
      2: return {m_lost, to_bcd(m_s)[6:0]};
      3: return to_bcd(m_m);
      4: return to_bcd(m_h);
      5: return to_bcd(m_d);
      6: return 8'(m_w);
      7: return {m_cent, 2'b00, to_bcd(m_mo)[4:0]};
      8: return to_bcd(m_y);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0: return "R9";
      2: return "R10";
      5: return "R5";
      6: return "R4";
      7: return "R7";
      2, 3, 4: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0: m_ctrl = d & 8'hA8;
      2: begin m_lost = d[7]; m_s = from_bcd(d & 8'h7F); end
      3: m_m = from_bcd(d & 8'h7F);
      4: m_h = from_bcd(d & 8'h3F);
      5: m_d = from_bcd(d & 8'h3F);
      6: m_w = int'(d & 8'h07);
      7: begin m_cent = d[7]; m_mo = from_bcd(d & 8'h1F); end
      8: m_y = from_bcd(d);
      default: ;
    endcase
  endtask

  // returns 1 when the seconds wrapped
  function automatic bit model_tick();
    if (m_ctrl[5]) return 1'b0;
    if (m_s < 59) begin m_s++; return 1'b0; end
    m_s = 0;
    if (m_m < 59) begin m_m++; return 1'b1; end
    m_m = 0;
    if (m_h < 23) begin m_h++; return 1'b1; end
    m_h = 0;
    m_w = (m_w >= 6) ? 0 : m_w + 1;
    if (m_d < month_days(m_mo, m_y)) begin m_d++; return 1'b1; end
    m_d = 1;
    if (m_mo < 12) begin m_mo++; return 1'b1; end
    m_mo = 1;
    if (m_y < 99) begin m_y++; return 1'b1; end
    m_y = 0;
    m_cent = ~m_cent;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic verify_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      reg_rd_addr = 4'(a);
      #1;
      check((tag == "") ? req_of(a) : tag, reg_rd_data, model_read(a));
    end
  endtask

  // one clock with optional tick and write, driven at the falling edge
  task automatic cycle(input bit tk, input bit wr, input int a, input logic [7:0] d);
    bit wrapped;
    @(negedge clk);
    tick_1hz    = tk;
    reg_wr_en   = wr;
    reg_wr_addr = 4'(a);
    reg_wr_data = d;
    @(posedge clk);
    #1;
    tick_1hz  = 1'b0;
    reg_wr_en = 1'b0;
    wrapped = 1'b0;
    if (wr) model_write(a, d);
    else if (tk) wrapped = model_tick();
    check("R11", {7'b0, sec_rollover}, {7'b0, wrapped});
    @(posedge clk);
    #1;
    check("R11", {7'b0, sec_rollover}, 8'h00);
  endtask

  task automatic do_tick();
    cycle(1'b1, 1'b0, 0, 8'h00);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    cycle(1'b0, 1'b1, a, d);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int w,
                          input int h, input int mi, input int s);
    do_write(0, 8'h20);
    do_write(2, to_bcd(s));
    do_write(3, to_bcd(mi));
    do_write(4, to_bcd(h));
    do_write(5, to_bcd(d));
    do_write(6, 8'(w));
    do_write(7, {m_cent, 2'b00, to_bcd(mo)[4:0]});
    do_write(8, to_bcd(y));
    do_write(0, 8'h00);
  endtask

  function automatic logic [7:0] rand_val(input int a);
    int r;
    r = int'($urandom % 100);
    case (a)
      2: return {1'($urandom), to_bcd((r < 50) ? 59 : r % 60)[6:0]};
      3: return to_bcd((r < 50) ? 59 : r % 60);
      4: return to_bcd((r < 50) ? 23 : r % 24);
      5: return to_bcd(1 + r % 31);
      6: return 8'(r % 7);
      7: return {1'($urandom), 2'b00, to_bcd(1 + r % 12)[4:0]};
      8: return to_bcd((r < 20) ? 99 : r);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_s = 0; m_m = 0; m_h = 0; m_d = 1; m_w = 0; m_mo = 1; m_y = 0;
    m_cent = 1'b0; m_lost = 1'b1; m_ctrl = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents
    verify_all("R1");
    check("R11", {7'b0, sec_rollover}, 8'h00);

    // R2 unmapped addresses ignore writes and read zero
    do_write(1, 8'hFF);
    do_write(12, 8'h5A);
    do_write(15, 8'hC3);
    verify_all("R2");
    // R2 field masks on write
    do_write(3, 8'hD9);
    do_write(4, 8'hE3);
    do_write(6, 8'hFD);
    do_write(6, 8'h00);
    verify_all("R2");

    // R10 clear integrity flag, then counting keeps it
    do_write(2, 8'h58);
    verify_all("R10");
    repeat (3) do_tick();
    verify_all("R10");
    do_write(2, 8'h80);
    do_tick();
    verify_all("R10");
    do_write(2, 8'h00);

    // R3 R4 R5 end of a 28-day February, weekday 6 to 0
    set_time(23, 2, 28, 6, 23, 59, 58);
    do_tick(); do_tick();
    verify_all("R5");

    // R6 leap year February reaches 29, then March
    set_time(24, 2, 28, 3, 23, 59, 59);
    do_tick();
    verify_all("R6");
    set_time(24, 2, 29, 4, 23, 59, 59);
    do_tick();
    verify_all("R6");
    set_time(0, 2, 28, 1, 23, 59, 59);
    do_tick();
    verify_all("R6");

    // R5 30-day month
    set_time(31, 4, 30, 2, 23, 59, 59);
    do_tick();
    verify_all("R5");

    // R7 year and century wrap, twice
    set_time(99, 12, 31, 5, 23, 59, 59);
    do_tick();
    verify_all("R7");
    set_time(99, 12, 31, 5, 23, 59, 59);
    do_tick();
    verify_all("R7");

    // R8 ticks during freeze are lost
    do_write(0, 8'h20);
    repeat (5) do_tick();
    verify_all("R8");
    do_write(0, 8'h00);

    // R9 test bits stored, counting unaffected
    do_write(0, 8'h88);
    repeat (2) do_tick();
    verify_all("R9");
    do_write(0, 8'h00);

    // R12 tick together with writes
    cycle(1'b1, 1'b1, 3, 8'h12);
    cycle(1'b1, 1'b1, 9, 8'h77);
    verify_all("R12");

    // R3 long run across minute and hour carries
    set_time(50, 6, 15, 2, 10, 58, 0);
    for (int i = 0; i < 200; i++) do_tick();
    verify_all("R3");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6) do_tick();
      else if (op == 6) begin
        int a;
        a = 2 + int'($urandom % 7);
        do_write(a, rand_val(a));
      end else if (op == 7) do_write(0, 8'($urandom));
      else if (op == 8) do_write(0, 8'h00);
      else begin
        int a;
        a = 2 + int'($urandom % 7);
        cycle(1'b1, 1'b1, a, rand_val(a));
      end
      verify_all("");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule